// File: doc/BRIEF.md
# USB Device Slot State Tracker

This block holds the host-side view of a single USB device slot and executes slot commands against it. A command arrives as an opcode plus operands (a device address for address assignment, an endpoint mask for configuration). The block checks the command against the slot's current state, updates the tracked state, device address and endpoint-enable vector, and returns a one-cycle completion carrying a result code. A successful enable-slot completion also carries the slot identifier.

The state, address and endpoint enables are driven out continuously, so that transfer-scheduling logic further down the chip can decide whether a transfer to a given endpoint is permitted. There are four slot states, encoded 2'b00 disabled, 2'b01 default, 2'b10 addressed and 2'b11 configured. Endpoint 0, the control endpoint, is bit 0 of the enable vector.

Top module: `slot_state_tracker`

## Requirements
- R1: With `rst` high at a clock edge, the slot becomes disabled (2'b00) with address 0, all endpoint enables clear, `cpl_valid` low and `cmd_ready` high.
- R2: A command is accepted when `cmd_valid` and `cmd_ready` are both high at a clock edge. Each accepted command raises `cpl_valid` for exactly the following cycle. Without an accepted command, `cpl_valid` stays low. Completion codes are 2'b00 success, 2'b01 context-state error and 2'b10 slot-not-enabled error.
- R3: Enable slot (opcode 0) from disabled succeeds: the state becomes default (2'b01), the address 0 and the endpoint enables exactly bit 0, and `cpl_slot_id` equals `SLOT_ID`. From any other state it returns code 2'b01 and changes nothing. `cpl_slot_id` is 0 on every other completion.
- R4: `cmd_ready` is low for exactly the one cycle in which a successful enable completion is presented. A command offered during that cycle is ignored: it produces no completion and no state change.
- R5: Set address, configure and reset (opcodes 2, 3 and 4) on a disabled slot return code 2'b10 and change nothing.
- R6: Set address (opcode 2) from default with a non-zero `cmd_addr` succeeds, moves to addressed (2'b10) and loads the address. An address of 0, or any other enabled state, gives code 2'b01 and no change.
- R7: Configure (opcode 3) from addressed or configured, with any mask bit above bit 0 set, succeeds and moves to configured (2'b11). The enables become the mask with bit 0 forced on; mask bit 0 has no effect. From default the command gives code 2'b01 and no change.
- R8: Configure from addressed or configured with mask bits 1 and up all zero succeeds, returns to addressed and leaves only endpoint 0 enabled.
- R9: Reset device (opcode 4) from addressed or configured succeeds, moves to default, clears the address and leaves only endpoint 0 enabled.
- R10: Reset device from default returns code 2'b01 and leaves the state, address and every endpoint enable unchanged.
- R11: Disable slot (opcode 1) succeeds from any state and leaves the slot disabled, with address 0 and no endpoint enabled.
- R12: Opcodes 5 to 7 return code 2'b01 in every state and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | ADDR_W | Address operand for set address |
| cmd_ep_mask | input | NUM_EP | Endpoint mask operand for configure |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cpl_valid | output | 1 | Completion strobe, one cycle per accepted command |
| cpl_code | output | 2 | Completion result code |
| cpl_slot_id | output | SLOT_W | Slot identifier on a successful enable completion, else 0 |
| slot_state | output | 2 | Current slot state |
| dev_addr | output | ADDR_W | Current device address |
| ep_enable | output | NUM_EP | Endpoint enable vector, bit 0 is the control endpoint |

## Verification
The bench targets reset from the default state. A design that accepted it would report success and move no state, while one that cleared enables on failure would drop endpoint 0. It offers a command in the cycle right after an enable, where a design that did not stall would emit an extra completion. Set address with address 0 catches a design that enters addressed with a zero address. Configure with an empty mask, or with mask bit 0 clear, catches designs that go to configured with no data endpoints or that turn off the control endpoint.

// File: rtl/slot_trk_pkg.sv
package slot_trk_pkg;

    typedef enum logic [1:0] {
        ST_DISABLED   = 2'b00,
        ST_DEFAULT    = 2'b01,
        ST_ADDRESSED  = 2'b10,
        ST_CONFIGURED = 2'b11
    } slot_state_e;

    typedef enum logic [1:0] {
        CC_SUCCESS     = 2'b00,
        CC_CTX_STATE   = 2'b01,
        CC_NOT_ENABLED = 2'b10
    } cpl_code_e;

    typedef enum logic [1:0] {
        ADDR_KEEP,
        ADDR_CLEAR,
        ADDR_LOAD
    } addr_act_e;

    typedef enum logic [1:0] {
        EP_KEEP,
        EP_CLEAR_ALL,
        EP_ONLY_CTRL,
        EP_LOAD_MASK
    } ep_act_e;

    localparam logic [2:0] OP_ENABLE   = 3'd0;
    localparam logic [2:0] OP_DISABLE  = 3'd1;
    localparam logic [2:0] OP_SET_ADDR = 3'd2;
    localparam logic [2:0] OP_CONFIG   = 3'd3;
    localparam logic [2:0] OP_RESET    = 3'd4;

    typedef struct packed {
        logic        apply;
        slot_state_e nxt;
        addr_act_e   addr_act;
        ep_act_e     ep_act;
        cpl_code_e   code;
        logic        give_id;
    } slot_dec_t;

    function automatic logic is_live(input slot_state_e st);
        return (st == ST_ADDRESSED) || (st == ST_CONFIGURED);
    endfunction

    function automatic slot_dec_t slot_decide(
        input logic [2:0]  op,
        input slot_state_e st,
        input logic        addr_nz,
        input logic        mask_nz
    );
        slot_dec_t d;
        d.apply    = 1'b0;
        d.nxt      = st;
        d.addr_act = ADDR_KEEP;
        d.ep_act   = EP_KEEP;
        d.code     = CC_CTX_STATE;
        d.give_id  = 1'b0;
        case (op)
            OP_ENABLE: begin
                if (st == ST_DISABLED) begin
                    d.apply    = 1'b1;
                    d.nxt      = ST_DEFAULT;
                    d.addr_act = ADDR_CLEAR;
                    d.ep_act   = EP_ONLY_CTRL;
                    d.code     = CC_SUCCESS;
                    d.give_id  = 1'b1;
                end
            end
            OP_DISABLE: begin
                d.apply    = 1'b1;
                d.nxt      = ST_DISABLED;
                d.addr_act = ADDR_CLEAR;
                d.ep_act   = EP_CLEAR_ALL;
                d.code     = CC_SUCCESS;
            end
            OP_SET_ADDR: begin
                if (st == ST_DISABLED) begin
                    d.code = CC_NOT_ENABLED;
                end else if (st == ST_DEFAULT && addr_nz) begin
                    d.apply    = 1'b1;
                    d.nxt      = ST_ADDRESSED;
                    d.addr_act = ADDR_LOAD;
                    d.code     = CC_SUCCESS;
                end
            end
            OP_CONFIG: begin
                if (st == ST_DISABLED) begin
                    d.code = CC_NOT_ENABLED;
                end else if (is_live(st)) begin
                    d.apply  = 1'b1;
                    d.nxt    = mask_nz ? ST_CONFIGURED : ST_ADDRESSED;
                    d.ep_act = mask_nz ? EP_LOAD_MASK : EP_ONLY_CTRL;
                    d.code   = CC_SUCCESS;
                end
            end
            OP_RESET: begin
                if (st == ST_DISABLED) begin
                    d.code = CC_NOT_ENABLED;
                end else if (is_live(st)) begin
                    d.apply    = 1'b1;
                    d.nxt      = ST_DEFAULT;
                    d.addr_act = ADDR_CLEAR;
                    d.ep_act   = EP_ONLY_CTRL;
                    d.code     = CC_SUCCESS;
                end
            end
            default: d.code = CC_CTX_STATE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/slot_cmd_decode.sv
module slot_cmd_decode
    import slot_trk_pkg::*;
#(
    parameter int NUM_EP = 31,
    parameter int ADDR_W = 7
) (
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_EP-1:0] ep_mask,
    input  slot_state_e       cur_state,
    output slot_dec_t         dec
);
    logic addr_nz;
    logic mask_nz;

    assign addr_nz = |addr;
    assign mask_nz = |ep_mask[NUM_EP-1:1];

    always_comb begin
        dec = slot_decide(op, cur_state, addr_nz, mask_nz);
    end
endmodule

// File: rtl/slot_ctx_regs.sv
module slot_ctx_regs
    import slot_trk_pkg::*;
#(
    parameter int NUM_EP = 31,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  slot_dec_t         dec,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic [NUM_EP-1:0] new_mask,
    output slot_state_e       state_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [NUM_EP-1:0] ep_q
);
    localparam logic [NUM_EP-1:0] CTRL_ONLY = NUM_EP'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DISABLED;
            addr_q  <= '0;
            ep_q    <= '0;
        end else if (accept && dec.apply) begin
            state_q <= dec.nxt;
            case (dec.addr_act)
                ADDR_CLEAR: addr_q <= '0;
                ADDR_LOAD:  addr_q <= new_addr;
                default:    addr_q <= addr_q;
            endcase
            case (dec.ep_act)
                EP_CLEAR_ALL: ep_q <= '0;
                EP_ONLY_CTRL: ep_q <= CTRL_ONLY;
                EP_LOAD_MASK: ep_q <= new_mask | CTRL_ONLY;
                default:      ep_q <= ep_q;
            endcase
        end
    end
endmodule

// File: rtl/slot_cpl_out.sv
module slot_cpl_out
    import slot_trk_pkg::*;
#(
    parameter int              SLOT_W  = 8,
    parameter logic [SLOT_W-1:0] SLOT_ID = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  slot_dec_t         dec,
    output logic              cpl_valid_q,
    output cpl_code_e         cpl_code_q,
    output logic [SLOT_W-1:0] cpl_id_q,
    output logic              ready_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cpl_valid_q <= 1'b0;
            cpl_code_q  <= CC_SUCCESS;
            cpl_id_q    <= '0;
            ready_q     <= 1'b1;
        end else begin
            cpl_valid_q <= accept;
            ready_q     <= !(accept && dec.give_id);
            if (accept) begin
                cpl_code_q <= dec.code;
                cpl_id_q   <= dec.give_id ? SLOT_ID : '0;
            end
        end
    end
endmodule

// File: rtl/slot_state_tracker.sv
module slot_state_tracker
    import slot_trk_pkg::*;
#(
    parameter int                NUM_EP  = 31,
    parameter int                ADDR_W  = 7,
    parameter int                SLOT_W  = 8,
    parameter logic [SLOT_W-1:0] SLOT_ID = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [NUM_EP-1:0] cmd_ep_mask,
    output logic              cmd_ready,
    output logic              cpl_valid,
    output logic [1:0]        cpl_code,
    output logic [SLOT_W-1:0] cpl_slot_id,
    output logic [1:0]        slot_state,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [NUM_EP-1:0] ep_enable
);
    slot_dec_t   dec;
    slot_state_e state_q;
    cpl_code_e   code_q;
    logic        accept;

    assign accept = cmd_valid && cmd_ready;

    slot_cmd_decode #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_dec (
        .op        (cmd_op),
        .addr      (cmd_addr),
        .ep_mask   (cmd_ep_mask),
        .cur_state (state_q),
        .dec       (dec)
    );

    slot_ctx_regs #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_ctx (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .dec      (dec),
        .new_addr (cmd_addr),
        .new_mask (cmd_ep_mask),
        .state_q  (state_q),
        .addr_q   (dev_addr),
        .ep_q     (ep_enable)
    );

    slot_cpl_out #(.SLOT_W(SLOT_W), .SLOT_ID(SLOT_ID)) u_cpl (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .dec         (dec),
        .cpl_valid_q (cpl_valid),
        .cpl_code_q  (code_q),
        .cpl_id_q    (cpl_slot_id),
        .ready_q     (cmd_ready)
    );

    assign slot_state = state_q;
    assign cpl_code   = code_q;
endmodule

// File: rtl/slot_state_tracker_chk.sv
module slot_state_tracker_chk #(
    parameter int NUM_EP = 31,
    parameter int ADDR_W = 7,
    parameter int SLOT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cmd_ready,
    input logic              cpl_valid,
    input logic [1:0]        cpl_code,
    input logic [1:0]        slot_state,
    input logic [ADDR_W-1:0] dev_addr,
    input logic [NUM_EP-1:0] ep_enable
);
    logic taken;
    assign taken = cmd_valid && cmd_ready;

    AST_CPL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        taken |=> cpl_valid);                                            // R2
    AST_NO_SPURIOUS_CPL: assert property (@(posedge clk) disable iff (rst)
        !taken |=> !cpl_valid);                                          // R4
    AST_ADDR_ZERO_EARLY: assert property (@(posedge clk) disable iff (rst)
        (slot_state == 2'b00 || slot_state == 2'b01) |-> dev_addr == '0); // R9
    AST_ADDR_SET_LATER: assert property (@(posedge clk) disable iff (rst)
        (slot_state == 2'b10 || slot_state == 2'b11) |-> dev_addr != '0); // R6
    AST_DISABLED_NO_EP: assert property (@(posedge clk) disable iff (rst)
        (slot_state == 2'b00) |-> ep_enable == '0);                      // R11
    AST_CTRL_EP_ON: assert property (@(posedge clk) disable iff (rst)
        (slot_state != 2'b00) |-> ep_enable[0]);                         // R7
    AST_RESET_DEFAULT_FAILS: assert property (@(posedge clk) disable iff (rst)
        (taken && cmd_op == 3'd4 && slot_state == 2'b01)
        |=> (cpl_code == 2'b01 && $stable(ep_enable) && $stable(slot_state))); // R10
    AST_ZERO_ADDR_REJECT: assert property (@(posedge clk) disable iff (rst)
        (taken && cmd_op == 3'd2 && cmd_addr == '0) |=> cpl_code != 2'b00); // R6
    AST_RESET_OK_CTRL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (taken && cmd_op == 3'd4 && (slot_state == 2'b10 || slot_state == 2'b11))
        |=> (slot_state == 2'b01 && $countones(ep_enable) == 1 && ep_enable[0])); // R9
endmodule

bind slot_state_tracker slot_state_tracker_chk #(
    .NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_ready  (cmd_ready),
    .cpl_valid  (cpl_valid),
    .cpl_code   (cpl_code),
    .slot_state (slot_state),
    .dev_addr   (dev_addr),
    .ep_enable  (ep_enable)
);

// File: tb/slot_state_tracker_test.sv
module slot_state_tracker_test;
    localparam int NUM_EP = 31;
    localparam int ADDR_W = 7;
    localparam int SLOT_W = 8;
    localparam logic [SLOT_W-1:0] SID = 8'd5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [NUM_EP-1:0] cmd_ep_mask = '0;
    logic              cmd_ready;
    logic              cpl_valid;
    logic [1:0]        cpl_code;
    logic [SLOT_W-1:0] cpl_slot_id;
    logic [1:0]        slot_state;
    logic [ADDR_W-1:0] dev_addr;
    logic [NUM_EP-1:0] ep_enable;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [1:0]        m_state;
    logic [ADDR_W-1:0] m_addr;
    logic [NUM_EP-1:0] m_ep;
    logic              m_ready;

    always #5 clk = ~clk;

    slot_state_tracker #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .SLOT_ID(SID)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_ep_mask(cmd_ep_mask), .cmd_ready(cmd_ready), .cpl_valid(cpl_valid),
        .cpl_code(cpl_code), .cpl_slot_id(cpl_slot_id), .slot_state(slot_state),
        .dev_addr(dev_addr), .ep_enable(ep_enable)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_ctx(input string req);
        chk(slot_state == m_state, req, "slot_state", 64'(slot_state), 64'(m_state));
        chk(dev_addr == m_addr, req, "dev_addr", 64'(dev_addr), 64'(m_addr));
        chk(ep_enable == m_ep, req, "ep_enable", 64'(ep_enable), 64'(m_ep));
        chk(cmd_ready == m_ready, req, "cmd_ready", 64'(cmd_ready), 64'(m_ready));
    endtask

    function automatic string req_of(input logic [2:0] op, input logic [1:0] st);
        if (op > 3'd4) return "R12";
        if (op == 3'd1) return "R11";
        if (op == 3'd0) return "R3";
        if (st == 2'b00) return "R5";
        if (op == 3'd2) return "R6";
        if (op == 3'd3) return "R7";
        return (st == 2'b01) ? "R10" : "R9";
    endfunction

    // Expected completion code from the requirement tables (R3, R5-R12)
    function automatic logic [1:0] exp_code(input logic [2:0] op, input logic [1:0] st,
                                            input logic [ADDR_W-1:0] a);
        if (op > 3'd4) return 2'b01;
        if (op == 3'd1) return 2'b00;
        if (op == 3'd0) return (st == 2'b00) ? 2'b00 : 2'b01;
        if (st == 2'b00) return 2'b10;
        if (op == 3'd2) return (st == 2'b01 && a != 0) ? 2'b00 : 2'b01;
        return (st == 2'b10 || st == 2'b11) ? 2'b00 : 2'b01;
    endfunction

    task automatic issue(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                         input logic [NUM_EP-1:0] mask, input string tag);
        logic       acc;
        logic [1:0] code;
        acc  = m_ready;
        code = exp_code(op, m_state, a);
        cmd_valid   = 1'b1;
        cmd_op      = op;
        cmd_addr    = a;
        cmd_ep_mask = mask;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        if (acc && code == 2'b00) begin
            case (op)
                3'd0: begin m_state = 2'b01; m_addr = '0; m_ep = NUM_EP'(1); end
                3'd1: begin m_state = 2'b00; m_addr = '0; m_ep = '0; end
                3'd2: begin m_state = 2'b10; m_addr = a; end
                3'd3: begin
                    if (mask[NUM_EP-1:1] != 0) begin m_state = 2'b11; m_ep = mask | NUM_EP'(1); end
                    else begin m_state = 2'b10; m_ep = NUM_EP'(1); end
                end
                default: begin m_state = 2'b01; m_addr = '0; m_ep = NUM_EP'(1); end
            endcase
        end
        m_ready = !(acc && op == 3'd0 && code == 2'b00);
        chk(cpl_valid == acc, acc ? "R2" : "R4", "cpl_valid", 64'(cpl_valid), 64'(acc));
        if (acc) begin
            chk(cpl_code == code, tag, "cpl_code", 64'(cpl_code), 64'(code));
            chk(cpl_slot_id == ((op == 3'd0 && code == 2'b00) ? SID : 8'd0), "R3", "cpl_slot_id",
                64'(cpl_slot_id), 64'((op == 3'd0 && code == 2'b00) ? SID : 8'd0));
        end
        chk_ctx(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_state = 2'b00; m_addr = '0; m_ep = '0; m_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk(cpl_valid == 1'b0, "R1", "cpl_valid", 64'(cpl_valid), 0);
        chk_ctx("R1");

        issue(3'd2, 7'd9, '0, "R5");            // set address on disabled slot
        issue(3'd4, 7'd0, '0, "R5");
        issue(3'd0, 7'd0, '0, "R3");            // enable
        issue(3'd3, 7'd0, 31'h6, "R4");         // offered while not ready: ignored
        issue(3'd0, 7'd0, '0, "R3");            // second enable: context error
        issue(3'd4, 7'd0, '0, "R10");           // reset from default fails
        issue(3'd3, 7'd0, 31'h6, "R7");         // configure from default fails
        issue(3'd2, 7'd0, '0, "R6");            // zero address rejected
        issue(3'd2, 7'd44, '0, "R6");
        issue(3'd2, 7'd12, '0, "R6");           // second set address rejected
        issue(3'd3, 7'd0, 31'h6, "R7");         // bit 0 clear in mask, ctrl stays on
        issue(3'd3, 7'd0, 31'h4000_0001, "R7");
        issue(3'd3, 7'd0, 31'h1, "R8");         // empty data mask: back to addressed
        issue(3'd3, 7'd0, 31'h30, "R7");
        issue(3'd6, 7'd3, 31'h7, "R12");
        issue(3'd4, 7'd0, '0, "R9");            // reset from configured
        issue(3'd2, 7'd1, '0, "R6");
        issue(3'd4, 7'd0, '0, "R9");            // reset from addressed
        issue(3'd1, 7'd0, '0, "R11");
        issue(3'd7, 7'd0, '0, "R12");
        issue(3'd1, 7'd0, '0, "R11");           // disable on disabled slot

        for (int i = 0; i < 800; i++) begin
            logic [2:0]        op;
            logic [ADDR_W-1:0] a;
            logic [NUM_EP-1:0] mk;
            int                sel;
            sel = $urandom_range(0, 19);
            if (sel < 4)       op = 3'd0;
            else if (sel < 5)  op = 3'd1;
            else if (sel < 10) op = 3'd2;
            else if (sel < 15) op = 3'd3;
            else if (sel < 18) op = 3'd4;
            else               op = 3'($urandom_range(5, 7));
            a  = ($urandom_range(0, 3) == 0) ? '0 : ADDR_W'($urandom);
            mk = ($urandom_range(0, 3) == 0) ? NUM_EP'($urandom_range(0, 1)) : NUM_EP'($urandom);
            if (!m_ready) issue(op, a, mk, "R4");
            else          issue(op, a, mk, req_of(op, m_state));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule